// File: doc/BRIEF.md
# Access Fault Classifier

The block watches every processor access and decides, in one clock, whether the access is refused. It compares the access address with the page table bits supplied for the addressed page and with the privilege of the processor. A refused access falls into one of four ranked classes: page not present, user access to kernel memory, user write to a write-protected page, or user access to the I/O region. Each class loads its own code into a general status register. Two bus status registers capture the transfer size, the byte lane and the faulting address.

The access strobe is a plain single-cycle qualifier. The block accepts a new access on every clock, so the access port never stalls and applies no back-pressure. Results appear on the clock after the strobe. A separate clear strobe returns the status registers to their idle value of all ones. The fault and bus-error outputs are one-cycle pulses. The fault output marks the classes that also need a top-priority interrupt. The bus-error output marks every refused access.

Top module: `fault_classifier`

## Requirements
- R1: An access at an address no higher than 0x3FFFFF whose page status `pg_stat` is 2'b00 (not present) is a page fault in either privilege. It loads general status 0x8BFF for a write and 0xCBFF for a read.
- R2: A user access (`cpu_super`=0) at an address no higher than 0x07FFFF is a kernel violation. It loads 0x9BFF for a write and 0xDBFF for a read.
- R3: A user write at an address no higher than 0x3FFFFF to a page with `pg_wren`=0 is a protection fault and loads 0x9BFF. User reads of such a page, and supervisor writes to it, are not refused.
- R4: A user access at an address of 0x400000 or above is an I/O violation. It loads 0x9AFF for a write and 0xDAFF for a read. The same access in supervisor mode is not refused.
- R5: The classes rank as follows: page fault first, then kernel violation, then protection fault, then I/O violation. Only the highest-ranked matching class loads its code.
- R6: When `parity_ie` is 1 at the faulting access, bit 10 (0x0400) is set in the loaded general status.
- R7: On a refused access, bus status 0 receives 0x7C00 when `acc_size` is not 2'b00 (word or long). A byte access (`acc_size`=2'b00) gives 0x7E00 at an odd address and 0x7D00 at an even address. Address bits [23:16] are ORed into bits [7:0].
- R8: On a refused access, bus status 1 receives address bits [15:0].
- R9: A clear strobe sets all three status registers to 0xFFFF on the next clock. If a refused access comes in the same cycle, the values of the refused access are loaded instead.
- R10: After reset all three status registers read 0xFFFF. Idle cycles and accepted accesses leave the registers unchanged.
- R11: Both pulses are raised for exactly the one cycle after the strobe of a refused access. `berr_o` is raised for every class. `fault_o` is raised for every class except the I/O violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_addr | input | 24 | Access address |
| acc_size | input | 2 | 00 byte, 01 word, 10 long |
| acc_write | input | 1 | 1 = write, 0 = read |
| cpu_super | input | 1 | 1 = supervisor mode |
| pg_stat | input | 2 | Status bits of the addressed page, 00 = not present |
| pg_wren | input | 1 | Write enable of the addressed page |
| parity_ie | input | 1 | Parity interrupt enable, reflected in general status |
| stat_clr | input | 1 | Clear strobe for the status registers |
| fault_o | output | 1 | Interrupt-class fault pulse |
| berr_o | output | 1 | Bus-error request pulse |
| gen_stat | output | 16 | General status register |
| bus_stat0 | output | 16 | Bus status 0: size, lane, high address |
| bus_stat1 | output | 16 | Bus status 1: low address |

## Verification
The clear strobe and the capture of a refused access are the two functions that can fall in the same cycle. The bench provokes this by raising `stat_clr` together with a faulting access. It expects the fault values in all three registers rather than 0xFFFF. It also pairs the clear strobe with an accepted access and expects all ones, which shows that the clear is only overridden by a real capture.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int FC_W = 16;

  typedef enum logic [2:0] {
    FC_NONE  = 3'd0,
    FC_PAGE  = 3'd1,
    FC_KERN  = 3'd2,
    FC_WPROT = 3'd3,
    FC_UIO   = 3'd4
  } fc_class_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } fc_size_e;

  typedef struct packed {
    logic [FC_W-1:0] gen;
    logic [FC_W-1:0] bs0;
    logic [FC_W-1:0] bs1;
  } fc_stat_t;

  localparam logic [FC_W-1:0] FC_IDLE   = 16'hFFFF;
  localparam logic [FC_W-1:0] FC_PIE_BIT = 16'h0400;

  // Status code for a class; read accesses also set bit 14
  function automatic logic [FC_W-1:0] fc_gen_code(fc_class_e cls, logic wr);
    logic [FC_W-1:0] c;
    case (cls)
      FC_PAGE:           c = 16'h8BFF;
      FC_KERN, FC_WPROT: c = 16'h9BFF;
      FC_UIO:            c = 16'h9AFF;
      default:           c = FC_IDLE;
    endcase
    if (!wr) c = c | 16'h4000;
    return c;
  endfunction
endpackage

// File: rtl/fc_classify.sv
module fc_classify #(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] RAM_TOP  = 24'h3FFFFF,
  parameter logic [ADDR_W-1:0] KERN_TOP = 24'h07FFFF,
  parameter logic [ADDR_W-1:0] IO_BASE  = 24'h400000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              sup,
  input  logic [1:0]        pg_stat,
  input  logic              pg_wren,
  output fc_pkg::fc_class_e cls
);
  import fc_pkg::*;

  logic in_ram, in_kern, in_io, absent;

  assign in_ram  = (addr <= RAM_TOP);
  assign in_kern = (addr <= KERN_TOP);
  assign in_io   = (addr >= IO_BASE);
  assign absent  = (pg_stat == 2'b00);

  // Ranked decision: earlier branch wins
  always_comb begin
    if (in_ram && absent)                 cls = FC_PAGE;
    else if (!sup && in_kern)             cls = FC_KERN;
    else if (!sup && wr && in_ram && !pg_wren) cls = FC_WPROT;
    else if (!sup && in_io)               cls = FC_UIO;
    else                                  cls = FC_NONE;
  end
endmodule

// File: rtl/fc_status_fmt.sv
module fc_status_fmt #(
  parameter int ADDR_W = 24
) (
  input  fc_pkg::fc_class_e cls,
  input  logic              wr,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pie,
  output fc_pkg::fc_stat_t  word
);
  import fc_pkg::*;

  localparam int HI_W = ADDR_W - 16;

  logic [FC_W-1:0] lane_code;
  logic [FC_W-1:0] hi_addr;

  always_comb begin
    if (fc_size_e'(size) == SZ_BYTE) lane_code = addr[0] ? 16'h7E00 : 16'h7D00;
    else                             lane_code = 16'h7C00;
  end

  assign hi_addr = {{(FC_W-HI_W){1'b0}}, addr[ADDR_W-1:16]};

  assign word.gen = fc_gen_code(cls, wr) | (pie ? FC_PIE_BIT : '0);
  assign word.bs0 = lane_code | hi_addr;
  assign word.bs1 = addr[15:0];
endmodule

// File: rtl/fc_status_regs.sv
module fc_status_regs #(
  parameter int NREG = 3,
  parameter int W    = 16,
  parameter logic [W-1:0] CLR_VAL = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   clr,
  input  logic [NREG-1:0][W-1:0] d,
  output logic [NREG-1:0][W-1:0] q
);
  // Capture has precedence over clear so an error is never dropped
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)    q[i] <= CLR_VAL;
      else if (load) q[i] <= d[i];
      else if (clr)  q[i] <= CLR_VAL;
    end
  end
endmodule

// File: rtl/fault_classifier.sv
module fault_classifier #(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] RAM_TOP  = 24'h3FFFFF,
  parameter logic [ADDR_W-1:0] KERN_TOP = 24'h07FFFF,
  parameter logic [ADDR_W-1:0] IO_BASE  = 24'h400000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic              acc_write,
  input  logic              cpu_super,
  input  logic [1:0]        pg_stat,
  input  logic              pg_wren,
  input  logic              parity_ie,
  input  logic              stat_clr,
  output logic              fault_o,
  output logic              berr_o,
  output logic [15:0]       gen_stat,
  output logic [15:0]       bus_stat0,
  output logic [15:0]       bus_stat1
);
  import fc_pkg::*;

  localparam int NREG = 3;

  fc_class_e cls;
  fc_stat_t  word;
  logic      refuse;
  logic [NREG-1:0][FC_W-1:0] reg_d, reg_q;

  fc_classify #(
    .ADDR_W(ADDR_W), .RAM_TOP(RAM_TOP), .KERN_TOP(KERN_TOP), .IO_BASE(IO_BASE)
  ) u_cls (
    .addr(acc_addr), .wr(acc_write), .sup(cpu_super),
    .pg_stat(pg_stat), .pg_wren(pg_wren), .cls(cls)
  );

  fc_status_fmt #(.ADDR_W(ADDR_W)) u_fmt (
    .cls(cls), .wr(acc_write), .size(acc_size), .addr(acc_addr),
    .pie(parity_ie), .word(word)
  );

  assign refuse = acc_valid && (cls != FC_NONE);
  assign reg_d  = {word.bs1, word.bs0, word.gen};

  fc_status_regs #(.NREG(NREG), .W(FC_W), .CLR_VAL(FC_IDLE)) u_regs (
    .clk(clk), .rst_n(rst_n), .load(refuse), .clr(stat_clr),
    .d(reg_d), .q(reg_q)
  );

  assign gen_stat  = reg_q[0];
  assign bus_stat0 = reg_q[1];
  assign bus_stat1 = reg_q[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_o <= 1'b0;
      berr_o  <= 1'b0;
    end else begin
      berr_o  <= refuse;
      fault_o <= refuse && (cls != FC_UIO);
    end
  end
endmodule

// File: rtl/fc_checker.sv
module fc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic [23:0] acc_addr,
  input logic        acc_write,
  input logic        cpu_super,
  input logic [1:0]  pg_stat,
  input logic        parity_ie,
  input logic        stat_clr,
  input logic        fault_o,
  input logic        berr_o,
  input logic [15:0] gen_stat,
  input logic [15:0] bus_stat0,
  input logic [15:0] bus_stat1
);
  a_r1_page_fault: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && pg_stat == 2'b00 && acc_addr <= 24'h3FFFFF
    |=> fault_o && !gen_stat[12] && (gen_stat[14] != $past(acc_write)));

  a_r4_super_io_ok: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && cpu_super && acc_addr >= 24'h400000 |=> !berr_o);

  a_r6_parity_bit: assert property (@(posedge clk) disable iff (!rst_n)
    berr_o |-> gen_stat[10] == $past(parity_ie));

  a_r7_high_addr: assert property (@(posedge clk) disable iff (!rst_n)
    berr_o |-> bus_stat0[7:0] == $past(acc_addr[23:16]));

  a_r8_low_addr: assert property (@(posedge clk) disable iff (!rst_n)
    berr_o |-> bus_stat1 == $past(acc_addr[15:0]));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> berr_o || (gen_stat == 16'hFFFF && bus_stat0 == 16'hFFFF && bus_stat1 == 16'hFFFF));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid && !stat_clr |=> $stable(gen_stat) && $stable(bus_stat0) && $stable(bus_stat1));

  a_r11_fault_implies_berr: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> berr_o);

  a_r11_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    berr_o |-> $past(acc_valid));
endmodule

bind fault_classifier fc_checker u_fc_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_write(acc_write), .cpu_super(cpu_super), .pg_stat(pg_stat),
  .parity_ie(parity_ie), .stat_clr(stat_clr), .fault_o(fault_o),
  .berr_o(berr_o), .gen_stat(gen_stat), .bus_stat0(bus_stat0),
  .bus_stat1(bus_stat1)
);

// File: tb/sim_fault_classifier.sv
`timescale 1ns/1ps
module sim_fault_classifier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [23:0] acc_addr = '0;
  logic [1:0] acc_size = 2'b01;
  logic acc_write = 1'b0;
  logic cpu_super = 1'b0;
  logic [1:0] pg_stat = 2'b11;
  logic pg_wren = 1'b1;
  logic parity_ie = 1'b0;
  logic stat_clr = 1'b0;
  logic fault_o, berr_o;
  logic [15:0] gen_stat, bus_stat0, bus_stat1;

  always #4 clk = ~clk;

  fault_classifier u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_write(acc_write), .cpu_super(cpu_super),
    .pg_stat(pg_stat), .pg_wren(pg_wren), .parity_ie(parity_ie),
    .stat_clr(stat_clr), .fault_o(fault_o), .berr_o(berr_o),
    .gen_stat(gen_stat), .bus_stat0(bus_stat0), .bus_stat1(bus_stat1)
  );

  typedef struct {
    int          due;
    logic [15:0] gen, bs0, bs1;
    logic        flt, be;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] m_gen = 16'hFFFF, m_bs0 = 16'hFFFF, m_bs1 = 16'hFFFF;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "gen_stat", gen_stat, e.gen);
        check(e.tag, "bus_stat0", bus_stat0, e.bs0);
        check(e.tag, "bus_stat1", bus_stat1, e.bs1);
        check(e.tag, "fault_o", {15'd0, fault_o}, {15'd0, e.flt});
        check(e.tag, "berr_o", {15'd0, berr_o}, {15'd0, e.be});
      end
    end
  end

  // Independent model of the ranking: 0 none, 1 page, 2 kernel, 3 protect, 4 io
  function automatic int classify(logic [23:0] a, logic wr, logic sup, logic [1:0] ps, logic we);
    if (a <= 24'h3FFFFF && ps == 2'b00) return 1;
    if (!sup && a <= 24'h07FFFF) return 2;
    if (!sup && wr && a <= 24'h3FFFFF && !we) return 3;
    if (!sup && a >= 24'h400000) return 4;
    return 0;
  endfunction

  // Driver: one access (with optional clear), plus the idle cycle after it
  task automatic op(bit v, logic [23:0] a, logic [1:0] sz, logic wr, logic sup,
                    logic [1:0] ps, logic we, logic pie, bit clr, string tag);
    int k;
    exp_t e;
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_size = sz; acc_write = wr;
    cpu_super = sup; pg_stat = ps; pg_wren = we; parity_ie = pie; stat_clr = clr;
    k = v ? classify(a, wr, sup, ps, we) : 0;
    if (k != 0) begin
      case (k)
        1: m_gen = wr ? 16'h8BFF : 16'hCBFF;
        2, 3: m_gen = wr ? 16'h9BFF : 16'hDBFF;
        default: m_gen = wr ? 16'h9AFF : 16'hDAFF;
      endcase
      if (pie) m_gen = m_gen | 16'h0400;
      m_bs0 = (sz == 2'b00) ? (a[0] ? 16'h7E00 : 16'h7D00) : 16'h7C00;
      m_bs0 = m_bs0 | {8'h00, a[23:16]};
      m_bs1 = a[15:0];
    end else if (clr) begin
      m_gen = 16'hFFFF; m_bs0 = 16'hFFFF; m_bs1 = 16'hFFFF;
    end
    e.due = cyc + 1; e.gen = m_gen; e.bs0 = m_bs0; e.bs1 = m_bs1;
    e.flt = (k != 0) && (k != 4); e.be = (k != 0); e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    acc_valid = 0; stat_clr = 0;
    e.due = cyc + 1; e.flt = 0; e.be = 0; e.tag = "R11 idle";
    q.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "reset gen_stat", gen_stat, 16'hFFFF);
    check("R10", "reset bus_stat0", bus_stat0, 16'hFFFF);
    check("R10", "reset bus_stat1", bus_stat1, 16'hFFFF);
    rst_n = 1;
    @(negedge clk);
    // R1: supervisor word read of absent page
    op(1, 24'h012345, 2'b01, 0, 1, 2'b00, 1, 0, 0, "R1 page read");
    // R2: user byte write to kernel space, even address
    op(1, 24'h050000, 2'b00, 1, 0, 2'b01, 1, 0, 0, "R2 kernel write");
    // R3: user byte write to protected page, odd address
    op(1, 24'h200001, 2'b00, 1, 0, 2'b10, 0, 0, 0, "R3 protect write");
    op(1, 24'h200000, 2'b01, 0, 0, 2'b10, 0, 0, 0, "R3 user read ok");
    op(1, 24'h200000, 2'b01, 1, 1, 2'b10, 0, 0, 0, "R3 super write ok");
    // R4 + R6: user long read of I/O with parity enable
    op(1, 24'h412345, 2'b10, 0, 0, 2'b11, 1, 1, 0, "R4 R6 io read");
    op(1, 24'h600000, 2'b01, 1, 1, 2'b11, 1, 0, 0, "R4 super io ok");
    op(1, 24'hC10002, 2'b01, 1, 0, 2'b11, 1, 0, 0, "R4 io write");
    // R5: ranking
    op(1, 24'h010000, 2'b01, 1, 0, 2'b00, 0, 0, 0, "R5 page over kernel");
    op(1, 24'h001000, 2'b00, 0, 0, 2'b00, 1, 0, 0, "R5 page read byte");
    op(1, 24'h060003, 2'b00, 1, 0, 2'b01, 0, 1, 0, "R5 R7 kernel over protect");
    // R9: clear alone, clear with fault, clear with accepted access
    op(0, 24'h000000, 2'b01, 0, 1, 2'b11, 1, 0, 1, "R9 clear");
    op(1, 24'h3ABCDE, 2'b00, 0, 1, 2'b00, 1, 0, 1, "R9 clear with fault");
    op(1, 24'h300000, 2'b01, 0, 1, 2'b11, 1, 0, 1, "R9 clear with accepted");
    // R10: accepted access and idle hold
    op(1, 24'h123456, 2'b00, 1, 0, 2'b00, 0, 0, 0, "R8 fault before hold");
    op(1, 24'h380000, 2'b01, 1, 0, 2'b11, 1, 0, 0, "R10 accepted hold");
    op(0, 24'h000000, 2'b01, 1, 0, 2'b00, 0, 0, 0, "R10 idle hold");
    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule